// File: doc/BRIEF.md
# Exception Vector and Priority Selector

This block decides which pending event a pipelined processor services next and computes the address the front end must fetch from. Every pipeline stage reports a vector of pending event flags for the instruction it holds. The block picks one event, reports its cause code and the stage to flush, and forms the handler address from the event base register. Most causes use a fixed per-cause offset. The system call and TLB-miss causes have dedicated slots, so the handler can sit right at the target with no jump stub. External interrupts use an autovector offset that comes from the interrupt controller.

Age is decided before priority. The deepest occupied stage holds the oldest instruction, and any event there wins, even when a younger instruction holds a more urgent cause. The fixed priority order only resolves ties inside a single instruction. A reset request overrides everything else and jumps to an absolute address that does not use the base register. A parameter sets that address for the architecture variant.

All results are registered. The redirect strobe, cause code, flush stage and target appear together one clock after the inputs that produced them.

Top module: `evsel_top`

## Requirements
- R1: When `rst_req` is high, the next cycle shows `redirect`=1, `ev_code`=0, `flush_stage`=NUM_STAGES-1 and a target of 32'h8000_0000 when VARIANT_B=0 or 32'hA000_0000 when VARIANT_B=1, whatever else is pending. The base register does not affect this target.
- R2: Stage s places its flags at `stage_flags[s*7 +: 7]`. Bit k flags cause code k+1: 1 instruction TLB miss, 2 instruction address fault, 3 illegal opcode, 4 system call, 5 data TLB miss, 6 data address fault, 7 external interrupt. Within one stage, the lowest code wins.
- R3: Stage NUM_STAGES-1 is the oldest. The highest-numbered stage with any flag set is selected and reported on `flush_stage`, even if a younger stage holds a lower (more urgent) code.
- R4: For codes 1 to 6, the target is `evba` plus a per-cause offset: code1 0x050, code2 0x008, code3 0x010, code4 0x100, code5 0x060, code6 0x018. The sum wraps modulo 2^32.
- R5: For code 7, the target is `evba` plus `autovec` zero-extended to 32 bits. The sum wraps modulo 2^32.
- R6: `redirect` is high in the cycle after any cycle in which `rst_req` or any flag is set. Code, stage and target are registered with it in that same cycle.
- R7: In the cycle after a cycle with no event, `redirect` is low and `ev_code`, `flush_stage` and `target` keep their previous values.
- R8: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset event request |
| stage_flags | input | NUM_STAGES*7 | Per-stage pending event flags |
| evba | input | ADDR_W | Event base register value |
| autovec | input | AVEC_W | Interrupt autovector offset |
| redirect | output | 1 | Handler redirect strobe |
| ev_code | output | 3 | Selected cause code |
| flush_stage | output | SW | Stage index whose instruction is flushed |
| target | output | ADDR_W | Handler fetch address |

## Verification
A wrong age or priority decision shows in the cycle after the stimulus as a wrong `flush_stage` or `ev_code` together with an offset target, so one registered cycle exposes it. Mixed vectors place urgent causes on younger stages and lazy causes on older ones, so that an inverted scan order or an inverted priority order changes the visible code. Hold errors, a base register leaking into the reset vector, and sign extension of the autovector each show up at once in `target`. Each of these is checked by a dedicated vector, and one of those vectors also checks the carry past bit 31.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
   localparam int NCAUSE = 7;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      EV_RESET  = 3'd0,
      EV_ITLB   = 3'd1,
      EV_IADDR  = 3'd2,
      EV_ILLOP  = 3'd3,
      EV_SCALL  = 3'd4,
      EV_DTLB   = 3'd5,
      EV_DADDR  = 3'd6,
      EV_EXTINT = 3'd7
   } ev_code_e;

   localparam logic [31:0] RST_ADDR_A = 32'h8000_0000;
   localparam logic [31:0] RST_ADDR_B = 32'hA000_0000;

   // per-cause offset from the base register, indexed by cause code
   localparam logic [11:0] CAUSE_OFFS [8] = '{
      12'h000, 12'h050, 12'h008, 12'h010, 12'h100, 12'h060, 12'h018, 12'h000
   };
endpackage

// File: rtl/evsel_stage_enc.sv
module evsel_stage_enc
   import evsel_pkg::*;
(
   input  logic [NCAUSE-1:0] flags,
   output logic              any,
   output ev_code_e          code
);
   always_comb begin
      any  = |flags;
      code = EV_EXTINT;
      for (int i = NCAUSE - 1; i >= 0; i--) begin
         if (flags[i]) code = ev_code_e'(CODE_W'(i + 1));
      end
   end
endmodule

// File: rtl/evsel_age_pick.sv
module evsel_age_pick
   import evsel_pkg::*;
#(
   parameter int NUM_STAGES = 3,
   parameter int SW         = 2
) (
   input  logic              any   [NUM_STAGES],
   input  ev_code_e          codes [NUM_STAGES],
   output logic              valid,
   output logic [SW-1:0]     stage,
   output ev_code_e          code
);
   // later iterations override earlier: the deepest stage (oldest) wins
   always_comb begin
      valid = 1'b0;
      stage = '0;
      code  = EV_RESET;
      for (int s = 0; s < NUM_STAGES; s++) begin
         if (any[s]) begin
            valid = 1'b1;
            stage = SW'(s);
            code  = codes[s];
         end
      end
   end
endmodule

// File: rtl/evsel_target.sv
module evsel_target
   import evsel_pkg::*;
#(
   parameter bit VARIANT_B = 1'b0,
   parameter int ADDR_W    = 32,
   parameter int AVEC_W    = 14
) (
   input  ev_code_e          code,
   input  logic [ADDR_W-1:0] evba,
   input  logic [AVEC_W-1:0] autovec,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] rst_addr;

   generate
      if (VARIANT_B) begin : g_var_b
         assign rst_addr = RST_ADDR_B;
      end else begin : g_var_a
         assign rst_addr = RST_ADDR_A;
      end
   endgenerate

   always_comb begin
      unique case (code)
         EV_RESET:  addr = rst_addr;
         EV_EXTINT: addr = evba + ADDR_W'(autovec);
         default:   addr = evba + ADDR_W'(CAUSE_OFFS[code]);
      endcase
   end
endmodule

// File: rtl/evsel_top.sv
module evsel_top
   import evsel_pkg::*;
#(
   parameter int NUM_STAGES = 3,
   parameter bit VARIANT_B  = 1'b0,
   parameter int ADDR_W     = 32,
   parameter int AVEC_W     = 14,
   localparam int SW        = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
   localparam int FLAG_W    = NUM_STAGES * NCAUSE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic [FLAG_W-1:0] stage_flags,
   input  logic [ADDR_W-1:0] evba,
   input  logic [AVEC_W-1:0] autovec,
   output logic              redirect,
   output logic [2:0]        ev_code,
   output logic [SW-1:0]     flush_stage,
   output logic [ADDR_W-1:0] target
);
   generate
      if (NUM_STAGES < 1) begin : g_bad_stages
         $error("evsel_top: NUM_STAGES must be at least 1");
      end
      if (ADDR_W != 32) begin : g_bad_addr
         $error("evsel_top: ADDR_W must be 32");
      end
      if (AVEC_W < 1 || AVEC_W > ADDR_W) begin : g_bad_avec
         $error("evsel_top: AVEC_W out of range");
      end
   endgenerate

   logic     st_any  [NUM_STAGES];
   ev_code_e st_code [NUM_STAGES];

   generate
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
         evsel_stage_enc u_enc (
            .flags (stage_flags[s*NCAUSE +: NCAUSE]),
            .any   (st_any[s]),
            .code  (st_code[s])
         );
      end
   endgenerate

   logic          pick_valid;
   logic [SW-1:0] pick_stage;
   ev_code_e      pick_code;

   evsel_age_pick #(.NUM_STAGES(NUM_STAGES), .SW(SW)) u_age (
      .any   (st_any),
      .codes (st_code),
      .valid (pick_valid),
      .stage (pick_stage),
      .code  (pick_code)
   );

   // reset request overrides everything else
   logic          sel_valid;
   logic [SW-1:0] sel_stage;
   ev_code_e      sel_code;

   always_comb begin
      if (rst_req) begin
         sel_valid = 1'b1;
         sel_stage = SW'(NUM_STAGES - 1);
         sel_code  = EV_RESET;
      end else begin
         sel_valid = pick_valid;
         sel_stage = pick_stage;
         sel_code  = pick_code;
      end
   end

   logic [ADDR_W-1:0] sel_addr;

   evsel_target #(.VARIANT_B(VARIANT_B), .ADDR_W(ADDR_W), .AVEC_W(AVEC_W)) u_tgt (
      .code    (sel_code),
      .evba    (evba),
      .autovec (autovec),
      .addr    (sel_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect    <= 1'b0;
         ev_code     <= '0;
         flush_stage <= '0;
         target      <= '0;
      end else begin
         redirect <= sel_valid;
         if (sel_valid) begin
            ev_code     <= sel_code;
            flush_stage <= sel_stage;
            target      <= sel_addr;
         end
      end
   end
endmodule

// File: rtl/evsel_chk.sv
module evsel_chk
   import evsel_pkg::*;
#(
   parameter int NUM_STAGES = 3,
   parameter bit VARIANT_B  = 1'b0,
   parameter int ADDR_W     = 32,
   parameter int AVEC_W     = 14,
   localparam int SW        = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
   localparam int FLAG_W    = NUM_STAGES * NCAUSE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_req,
   input logic [FLAG_W-1:0] stage_flags,
   input logic [ADDR_W-1:0] evba,
   input logic [AVEC_W-1:0] autovec,
   input logic              redirect,
   input logic [2:0]        ev_code,
   input logic [SW-1:0]     flush_stage,
   input logic [ADDR_W-1:0] target
);
   localparam logic [31:0] RADDR = VARIANT_B ? RST_ADDR_B : RST_ADDR_A;
   localparam logic [SW-1:0] OLDEST = SW'(NUM_STAGES - 1);

   a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (redirect && ev_code == 3'd0 && target == RADDR && flush_stage == OLDEST));

   a_r3_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && |stage_flags[(NUM_STAGES-1)*NCAUSE +: NCAUSE]) |=> (flush_stage == OLDEST));

   a_r4_cause_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && ev_code != 3'd0 && ev_code != 3'd7)
      |-> target == $past(evba) + ADDR_W'(CAUSE_OFFS[ev_code]));

   a_r5_autovector: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && ev_code == 3'd7) |-> target == $past(evba) + ADDR_W'($past(autovec)));

   a_r6_strobe_on_event: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || |stage_flags) |=> redirect);

   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req || |stage_flags) |=> !redirect);

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |-> ($stable(target) && $stable(ev_code) && $stable(flush_stage)));
endmodule

bind evsel_top evsel_chk #(
   .NUM_STAGES (NUM_STAGES),
   .VARIANT_B  (VARIANT_B),
   .ADDR_W     (ADDR_W),
   .AVEC_W     (AVEC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rst_req     (rst_req),
   .stage_flags (stage_flags),
   .evba        (evba),
   .autovec     (autovec),
   .redirect    (redirect),
   .ev_code     (ev_code),
   .flush_stage (flush_stage),
   .target      (target)
);

// File: tb/evsel_top_tb_top.sv
module evsel_top_tb_top;
   localparam int NS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0;
   logic [20:0] stage_flags = '0;
   logic [31:0] evba = '0;
   logic [13:0] autovec = '0;
   logic        redirect, redirect_b;
   logic [2:0]  ev_code, ev_code_b;
   logic [1:0]  flush_stage, flush_stage_b;
   logic [31:0] target, target_b;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   evsel_top #(.NUM_STAGES(NS), .VARIANT_B(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .stage_flags(stage_flags),
      .evba(evba), .autovec(autovec), .redirect(redirect), .ev_code(ev_code),
      .flush_stage(flush_stage), .target(target));

   evsel_top #(.NUM_STAGES(NS), .VARIANT_B(1'b1)) dut_b (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .stage_flags(stage_flags),
      .evba(evba), .autovec(autovec), .redirect(redirect_b), .ev_code(ev_code_b),
      .flush_stage(flush_stage_b), .target(target_b));

   typedef struct packed {
      logic        rr;
      logic [20:0] fl;
      logic [31:0] base;
      logic [13:0] av;
      logic        v;
      logic [2:0]  code;
      logic [1:0]  st;
      logic [31:0] tgt;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{1'b0, 21'h000004, 32'h0000_4000, 14'h0000, 1'b1, 3'd3, 2'd0, 32'h0000_4010, 4'd2}, // R2 illop alone
      '{1'b0, 21'h00007F, 32'h0000_4000, 14'h0000, 1'b1, 3'd1, 2'd0, 32'h0000_4050, 4'd2}, // R2 all causes, itlb wins
      '{1'b0, 21'h100001, 32'h0000_4000, 14'h1234, 1'b1, 3'd7, 2'd2, 32'h0000_5234, 4'd3}, // R3 old extint beats young itlb
      '{1'b0, 21'h001402, 32'h0000_4000, 14'h0000, 1'b1, 3'd4, 2'd1, 32'h0000_4100, 4'd3}, // R3 R4 scall in stage1
      '{1'b0, 21'h0C0080, 32'h0000_4000, 14'h0000, 1'b1, 3'd5, 2'd2, 32'h0000_4060, 4'd3}, // R3 dtlb oldest
      '{1'b0, 21'h000400, 32'hFFFF_FFF0, 14'h0000, 1'b1, 3'd4, 2'd1, 32'h0000_00F0, 4'd4}, // R4 wrap
      '{1'b0, 21'h000040, 32'hFFFF_F000, 14'h3FFF, 1'b1, 3'd7, 2'd0, 32'h0000_2FFF, 4'd5}, // R5 zero-ext, wrap
      '{1'b0, 21'h000000, 32'h1234_5678, 14'h0AAA, 1'b0, 3'd7, 2'd0, 32'h0000_2FFF, 4'd7}, // R7 idle holds
      '{1'b0, 21'h001000, 32'h0000_4000, 14'h0000, 1'b1, 3'd6, 2'd1, 32'h0000_4018, 4'd4}, // R4 daddr
      '{1'b1, 21'h004000, 32'h0000_4000, 14'h0000, 1'b1, 3'd0, 2'd2, 32'h8000_0000, 4'd1}, // R1 reset overrides
      '{1'b0, 21'h000201, 32'h0000_4000, 14'h0000, 1'b1, 3'd3, 2'd1, 32'h0000_4010, 4'd6}  // R6 stage1 beats stage0
   };

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      chk(8, "redirect in reset", {31'd0, redirect}, 32'd0);
      chk(8, "target in reset", target, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         rst_req     = VT[i].rr;
         stage_flags = VT[i].fl;
         evba        = VT[i].base;
         autovec     = VT[i].av;
         @(negedge clk);
         chk(int'(VT[i].req), $sformatf("vec%0d redirect", i), {31'd0, redirect}, {31'd0, VT[i].v});
         chk(int'(VT[i].req), $sformatf("vec%0d code", i), {29'd0, ev_code}, {29'd0, VT[i].code});
         chk(int'(VT[i].req), $sformatf("vec%0d stage", i), {30'd0, flush_stage}, {30'd0, VT[i].st});
         chk(int'(VT[i].req), $sformatf("vec%0d target", i), target, VT[i].tgt);
      end

      // R1 variant B reset vector, base register ignored
      rst_req = 1'b1; stage_flags = '0; evba = 32'h5555_0000;
      @(negedge clk);
      chk(1, "variant B reset target", target_b, 32'hA000_0000);
      chk(1, "variant A reset target, base ignored", target, 32'h8000_0000);

      // R6 strobe falls after single event, R7 hold
      rst_req = 1'b0;
      @(negedge clk);
      chk(6, "strobe one cycle", {31'd0, redirect}, 32'd0);
      chk(7, "hold after reset event", target, 32'h8000_0000);

      // R6 back-to-back events strobe each cycle
      stage_flags = 21'h000008; evba = 32'h0000_1000;
      @(negedge clk);
      chk(6, "first of pair", target, 32'h0000_1100);
      stage_flags = 21'h000010;
      @(negedge clk);
      chk(6, "second of pair redirect", {31'd0, redirect}, 32'd1);
      chk(6, "second of pair target", target, 32'h0000_1060);

      // R8 mid-run asynchronous reset
      rst_n = 1'b0;
      #1;
      chk(8, "async clear redirect", {31'd0, redirect}, 32'd0);
      chk(8, "async clear target", target, 32'd0);
      chk(8, "async clear code", {29'd0, ev_code}, 32'd0);
      stage_flags = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule